// File: doc/BRIEF.md
# Write-Protect and Status Register Gate

This block sits between the command decoder of a serial memory and its internal write engine. It holds the protection status register and rules on every write request from the decoder. A data write is either granted or denied. A status register write is held as pending until chip select is released. Only then does the new protection setting take effect and a grant pulse go out to the write engine.

Protection has three layers. The first is a write-enable latch that the host must set before each write. The second is a two-bit region field that protects part or all of the address space. The third is a hardware protect pin. The pin locks the status register only when the software lock bit in that same register is set. While the lock bit is set, the pin can also abort a status write that is still pending. Once the write has been committed, the pin has no effect on it.

Top module: `wp_status_gate`

## Requirements
- R1: After reset the status byte reads 0x00 and none of the grant or deny outputs is high.
- R2: An enable command sets the enable latch (status bit 1). A disable command clears it. Commands act only while chip select (active low) is low.
- R3: A data or status write received while the enable latch is clear is denied and is never granted.
- R4: The region field is status bits 3:2. Value 00 protects nothing. Value 01 protects addresses whose two top bits are 11. Value 10 protects addresses whose top bit is 1. Value 11 protects every address. A data write to a protected address is denied, and one to an unprotected address is granted.
- R5: An allowed status write commits on the first clock that sees chip select high. On commit, bits 3:2 and 7 take the written byte's bits 3:2 and 7, and the stat grant output pulses for one cycle. The other written bits are ignored, and status bits 6:4 read zero.
- R6: When the protect pin is low and the lock bit (status bit 7) is 1, a status write is denied.
- R7: If the lock bit is 1 and the protect pin falls while a status write is pending and chip select is still low, the write is cancelled. The block then pulses deny and leaves the register unchanged.
- R8: A protect pin fall after a status write has committed has no effect on the committed value.
- R9: While the lock bit is 0, the protect pin has no effect on status writes.
- R10: The enable latch clears on a write-done pulse and on any deny.
- R11: While the busy input is high, commands have no effect. Status bit 0 mirrors busy.
- R12: Grant and deny outputs are registered. Each is a one-cycle pulse in the cycle after the deciding input is sampled, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| wpN | input | 1 | Hardware protect pin, low protects |
| busy | input | 1 | Write engine busy |
| wrDone | input | 1 | Write cycle completed pulse |
| cmdWren | input | 1 | Enable-latch set command |
| cmdWrdi | input | 1 | Enable-latch clear command |
| cmdWrsr | input | 1 | Status write command |
| cmdWrite | input | 1 | Data write command |
| cmdData | input | 8 | Byte for a status write |
| cmdAddr | input | ADDR_W | Address for a data write |
| dataGrant | output | 1 | Data write allowed pulse |
| statGrant | output | 1 | Status write committed pulse |
| deny | output | 1 | Request refused or cancelled pulse |
| statusByte | output | 8 | Status byte for readback |

## Verification
The assertions check four things on every cycle. The grant and deny pulses never overlap. A data grant always follows a set enable latch, a non-busy cycle and a region field other than "all". The protection bits change only together with a stat grant. The enable latch rises only after an enable command. The other behaviours can only be shown by the bench's scenarios: the address decode for each region value, commit at chip select release, and cancellation by a pin fall. These also include the pin being ignored when unlocked and the pin having no effect after commit. Random data writes under random region settings are compared with a model of the decode.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       armStat;
    logic       cancelStat;
    logic       commitStat;
    logic       grantData;
    logic       deny;
    logic [1:0] newBp;
    logic       newLock;
  } gateStrobes_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              csN,
  input  logic              wpN,
  input  logic              busy,
  input  logic              wrDone,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wel,
  input  logic [1:0]        bp,
  input  logic              lock,
  input  logic              pend,
  input  logic              csPrev,
  input  logic              wpPrev,
  output gateStrobes_t      stb
);
  localparam int TOP = ADDR_W - 1;

  logic hwLock, wpFall, csRise, accept, inRegion;

  assign hwLock = lock & ~wpN;
  assign wpFall = wpPrev & ~wpN;
  assign csRise = ~csPrev & csN;
  assign accept = ~busy & ~csN & ~pend;

  always_comb begin
    unique case (bp)
      2'b00:   inRegion = 1'b0;
      2'b01:   inRegion = &cmdAddr[TOP -: 2];
      2'b10:   inRegion = cmdAddr[TOP];
      default: inRegion = 1'b1;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.newBp   = cmdData[3:2];
    stb.newLock = cmdData[7];
    if (wrDone) stb.clrWel = 1'b1;
    if (pend) begin
      if (lock && wpFall && !csN) begin
        stb.cancelStat = 1'b1;
        stb.deny       = 1'b1;
        stb.clrWel     = 1'b1;
      end else if (csRise) begin
        stb.commitStat = 1'b1;
      end
    end else if (accept) begin
      if (cmdWren) begin
        stb.setWel = 1'b1;
      end else if (cmdWrdi) begin
        stb.clrWel = 1'b1;
      end else if (cmdWrsr) begin
        if (!wel || hwLock) begin
          stb.deny   = 1'b1;
          stb.clrWel = 1'b1;
        end else begin
          stb.armStat = 1'b1;
        end
      end else if (cmdWrite) begin
        if (!wel || inRegion) begin
          stb.deny   = 1'b1;
          stb.clrWel = 1'b1;
        end else begin
          stb.grantData = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         wpN,
  input  logic         busy,
  input  gateStrobes_t stb,
  output logic         wel,
  output logic [1:0]   bp,
  output logic         lock,
  output logic         pend,
  output logic         csPrev,
  output logic         wpPrev,
  output logic         dataGrant,
  output logic         statGrant,
  output logic         deny,
  output logic [7:0]   statusByte
);
  logic [1:0] pendBp;
  logic       pendLock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel       <= 1'b0;
      bp        <= 2'b00;
      lock      <= 1'b0;
      pend      <= 1'b0;
      pendBp    <= 2'b00;
      pendLock  <= 1'b0;
      csPrev    <= 1'b1;
      wpPrev    <= 1'b1;
      dataGrant <= 1'b0;
      statGrant <= 1'b0;
      deny      <= 1'b0;
    end else begin
      csPrev    <= csN;
      wpPrev    <= wpN;
      dataGrant <= stb.grantData;
      statGrant <= stb.commitStat;
      deny      <= stb.deny;
      if (stb.clrWel)      wel <= 1'b0;
      else if (stb.setWel) wel <= 1'b1;
      if (stb.armStat) begin
        pend     <= 1'b1;
        pendBp   <= stb.newBp;
        pendLock <= stb.newLock;
      end else if (stb.cancelStat) begin
        pend <= 1'b0;
      end else if (stb.commitStat) begin
        pend <= 1'b0;
        bp   <= pendBp;
        lock <= pendLock;
      end
    end
  end

  assign statusByte = {lock, 3'b000, bp, wel, busy};
endmodule

// File: rtl/wp_status_gate.sv
module wp_status_gate
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wpN,
  input  logic              busy,
  input  logic              wrDone,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              dataGrant,
  output logic              statGrant,
  output logic              deny,
  output logic [7:0]        statusByte
);
  gateStrobes_t stb;
  logic       wel, lock, pend, csPrev, wpPrev;
  logic [1:0] bp;

  wpg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .csN(csN), .wpN(wpN), .busy(busy), .wrDone(wrDone),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .cmdWrite(cmdWrite), .cmdData(cmdData), .cmdAddr(cmdAddr),
    .wel(wel), .bp(bp), .lock(lock), .pend(pend),
    .csPrev(csPrev), .wpPrev(wpPrev), .stb(stb)
  );

  wpg_datapath i_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .busy(busy),
    .stb(stb), .wel(wel), .bp(bp), .lock(lock), .pend(pend),
    .csPrev(csPrev), .wpPrev(wpPrev), .dataGrant(dataGrant),
    .statGrant(statGrant), .deny(deny), .statusByte(statusByte)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       cmdWren,
  input logic       dataGrant,
  input logic       statGrant,
  input logic       deny,
  input logic [7:0] statusByte
);
  p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataGrant, statGrant, deny}));

  p_grant_needs_wel_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataGrant |-> $past(statusByte[1]));

  p_grant_not_all_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataGrant |-> ($past(statusByte[3:2]) != 2'b11));

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    dataGrant |-> !$past(busy));

  p_prot_on_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    !statGrant |-> $stable(statusByte[7:2]));

  p_wel_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[1]) |-> $past(cmdWren));
endmodule

bind wp_status_gate wpg_checker i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .cmdWren(cmdWren),
  .dataGrant(dataGrant), .statGrant(statGrant), .deny(deny),
  .statusByte(statusByte)
);

// File: tb/test_wp_status_gate.sv
module test_wp_status_gate;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 0, rstN = 0, csN = 1, wpN = 1, busy = 0, wrDone = 0;
  logic cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdWrite = 0;
  logic [7:0] cmdData = 0;
  logic [AW-1:0] cmdAddr = 0;
  logic dataGrant, statGrant, deny;
  logic [7:0] statusByte;
  int checks = 0, errors = 0;
  logic sg, sd, sx;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_status_gate #(.ADDR_W(AW)) i_wp_status_gate (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit isProt(logic [1:0] bp, logic [AW-1:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a[AW-1] & a[AW-2];
      2'b10: return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  // pulse one command for a cycle; capture outputs afterwards
  task automatic pulse(int kind, logic [7:0] d, logic [AW-1:0] a);
    cmdData = d; cmdAddr = a;
    case (kind)
      0: cmdWren = 1;
      1: cmdWrdi = 1;
      2: cmdWrsr = 1;
      default: cmdWrite = 1;
    endcase
    @(negedge clk);
    sg = dataGrant; sx = statGrant; sd = deny;
    cmdWren = 0; cmdWrdi = 0; cmdWrsr = 0; cmdWrite = 0;
  endtask

  task automatic releaseCs();
    csN = 1;
    @(negedge clk);
    sx = statGrant; sd = deny;
    @(negedge clk);
  endtask

  task automatic setStatus(logic [7:0] v);
    csN = 0; pulse(0, 0, 0); pulse(2, v, 0); releaseCs();
    wrDone = 1; @(negedge clk); wrDone = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    chk("R1 status", statusByte, 8'h00);
    chk("R1 pulses", {dataGrant, statGrant, deny}, 0);
    rstN = 1;
    @(negedge clk);

    // R2 enable/disable, chip select gating
    pulse(0, 0, 0);
    chk("R2 cs high ignored", statusByte[1], 0);
    csN = 0;
    pulse(0, 0, 0);
    chk("R2 wel set", statusByte[1], 1);
    pulse(1, 0, 0);
    chk("R2 wel clear", statusByte[1], 0);

    // R3 write without latch
    pulse(3, 0, 10'h005);
    chk("R3 data deny", {sg, sd}, 2'b01);
    pulse(2, 8'h8C, 0);
    chk("R3 status deny", sd, 1);
    csN = 1; @(negedge clk); @(negedge clk);
    chk("R3 status unchanged", statusByte, 8'h00);

    // R12 latency: grant visible exactly one negedge after command
    csN = 0; pulse(0, 0, 0); pulse(3, 0, 10'h3FF);
    chk("R12 grant pulse", sg, 1);
    @(negedge clk);
    chk("R12 grant one cycle", dataGrant, 0);
    chk("R10 wel held until done", statusByte[1], 1);
    wrDone = 1; @(negedge clk); wrDone = 0;
    chk("R10 wel cleared by done", statusByte[1], 0);

    // R5 commit at cs release; ignored bits
    pulse(0, 0, 0); pulse(2, 8'h7B, 0);
    chk("R5 no commit while selected", statusByte[3:2], 0);
    releaseCs();
    chk("R5 stat grant", sx, 1);
    chk("R5 status bits", statusByte & 8'hFE, 8'h0A);
    wrDone = 1; @(negedge clk); wrDone = 0;

    // R4 directed boundaries for each region value
    for (int b = 0; b < 4; b++) begin
      setStatus(8'(b << 2));
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a = AW'(k) << (AW - 2);
        csN = 0; pulse(0, 0, 0); pulse(3, 0, a | AW'(k));
        chk("R4 region decode", sg, isProt(2'(b), a) ? 0 : 1);
        wrDone = 1; @(negedge clk); wrDone = 0;
      end
    end
    // R4 random
    for (int n = 0; n < 60; n++) begin
      logic [1:0] b = 2'($urandom_range(0, 3));
      logic [AW-1:0] a = AW'($urandom);
      setStatus({4'b0, b, 2'b0});
      csN = 0; pulse(0, 0, 0); pulse(3, 0, a);
      chk("R4 random decode", {sg, sd}, isProt(b, a) ? 2'b01 : 2'b10);
      wrDone = 1; @(negedge clk); wrDone = 0;
      csN = 1; @(negedge clk);
    end

    // lock on, bp 01
    setStatus(8'h84);
    chk("R5 lock set", statusByte[7], 1);
    // R6 pin low locked
    wpN = 0; @(negedge clk);
    csN = 0; pulse(0, 0, 0); pulse(2, 8'h00, 0);
    chk("R6 hw lock deny", sd, 1);
    chk("R10 wel cleared by deny", statusByte[1], 0);
    releaseCs();
    chk("R6 status kept", statusByte[7:2], 6'h21);
    wpN = 1; @(negedge clk);

    // R7 cancel by pin fall
    csN = 0; pulse(0, 0, 0); pulse(2, 8'h00, 0);
    wpN = 0; @(negedge clk);
    chk("R7 cancel deny", deny, 1);
    releaseCs();
    chk("R7 no commit", sx, 0);
    chk("R7 status kept", statusByte[7:2], 6'h21);
    wpN = 1; @(negedge clk);

    // R8 fall after commit
    csN = 0; pulse(0, 0, 0); pulse(2, 8'h88, 0);
    releaseCs();
    wpN = 0; @(negedge clk); @(negedge clk);
    chk("R8 commit kept", statusByte[7:2], 6'h22);
    wpN = 1; @(negedge clk);
    wrDone = 1; @(negedge clk); wrDone = 0;

    // R9 lock off: pin ignored
    setStatus(8'h00);
    wpN = 0; @(negedge clk);
    csN = 0; pulse(0, 0, 0); pulse(2, 8'h04, 0);
    chk("R9 no deny when unlocked", sd, 0);
    releaseCs();
    chk("R9 commit with pin low", statusByte[3:2], 1);
    wpN = 1; @(negedge clk);
    wrDone = 1; @(negedge clk); wrDone = 0;

    // R11 busy
    busy = 1; csN = 0; @(negedge clk);
    chk("R11 busy bit", statusByte[0], 1);
    pulse(0, 0, 0);
    chk("R11 wren ignored", statusByte[1], 0);
    busy = 0; pulse(0, 0, 0); busy = 1;
    pulse(3, 0, 0);
    chk("R11 write ignored", {sg, sd}, 0);
    busy = 0; csN = 1; @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule